// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Window

This block is the register front end for two bus-master DMA channels of a disk controller. A simple I/O bus reaches a 16-byte window. Each channel holds three registers in that window: a command register, a status register and a 32-bit descriptor-table address. Only single-byte accesses reach the registers. A wider read returns all ones across its width, and a wider write is dropped. Read data comes back registered, one clock after the access strobe, together with a one-cycle valid pulse.

The status register combines three kinds of bits. Some bits load directly from a write. Some are write-one-to-clear. Bit 0 can only be changed by the data mover. The data mover sits outside this block and reports activity and errors through set/clear pulses. Each channel also has a drive interrupt input. This input is captured into a per-channel flag byte (bit 7) and sets the status interrupt bit on its rising edge. The flag bits are ORed into one interrupt output. That output is driven only while the interrupt-line register is nonzero.

Top module: `dmareg_top`

## Requirements
- R1: A read with `bus_size` other than 0 (1 = 16-bit, 2 or 3 = 32-bit) returns 0x0000FFFF or 0xFFFFFFFF and has no register effect. A write with `bus_size` other than 0 changes no register.
- R2: Channel n owns window bytes n*8..n*8+7. A write to one channel never alters the other channel.
- R3: Byte offsets 1 and 3 inside a channel read as 0xFF, and writes to them change nothing.
- R4: The command register (offset 0) keeps only bit 0 (start) and bit 3 (direction) of a written byte. All other bits read 0.
- R5: A status write (offset 2) loads bits 6:5 from the data and clears bits 2:1 wherever the data has a 1. It leaves bit 0 unchanged and forces bits 7, 4 and 3 to 0.
- R6: The mover pulses work as follows: `dma_act_set` sets status bit 0, `dma_act_clr` clears it, and `dma_err_set` sets bit 1. A rising edge on the drive interrupt sets bit 2. A hardware set wins over a clear written in the same cycle.
- R7: A channel's interrupt flag (`irq_flag[n]`, bit 7 of its flag byte) equals that channel's drive interrupt input as sampled at the previous clock edge.
- R8: `irq_out` is the OR of both flags while the interrupt-line register is nonzero, and 0 while it is zero.
- R9: Only bits 3:0 of the interrupt-line register are writable, and bits 7:4 read 0.
- R10: Offsets 4..7 are the descriptor-table address bytes, least significant first. Address bits 1:0 always read 0.
- R11: Reset clears command, status, address and flags of both channels, sets the interrupt-line register to 0x0E and drives `irq_out` low.
- R12: A read strobe returns `{24'h0, byte}` on `rd_data` with `rd_valid` high in the following cycle. A write strobe never raises `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access width: 0 byte, 1 half, 2/3 word |
| bus_addr | input | 4 | Byte offset in the window |
| bus_wdata | input | 8 | Write byte |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid pulse |
| drv_irq | input | 2 | Drive interrupt level per channel |
| dma_act_set | input | 2 | Mover sets status bit 0 |
| dma_act_clr | input | 2 | Mover clears status bit 0 |
| dma_err_set | input | 2 | Mover sets status bit 1 |
| line_we | input | 1 | Interrupt-line register write strobe |
| line_wdata | input | 8 | Interrupt-line write data |
| line_q | output | 8 | Interrupt-line register value |
| irq_flag | output | 2 | Per-channel captured interrupt flag |
| irq_out | output | 1 | Merged, gated interrupt |

## Verification
Status writes are driven with patterns that separate the three bit classes. 0x62 loads bits 6:5 while clearing bit 1 and sparing bit 2. 0x04 clears bit 2 and unloads bits 6:5. 0xFF shows that the reserved bits stay 0 and that bit 0 survives. A write that coincides with an error pulse shows that the hardware set wins. Distinct byte values are written to each address lane, which exposes lane swaps and a missing bit 1:0 mask. Command and open-offset writes to one channel are read back from both channels, so crossed decode shows up. The interrupt path is driven from each channel alone and from neither, under a zero, the reset and an upper-bit-laden line value. This separates the OR merge from the gate and from the write mask.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    localparam logic [7:0] CMD_KEEP   = 8'h09;
    localparam logic [7:0] STS_LOAD   = 8'h60;
    localparam logic [7:0] STS_W1C    = 8'h06;
    localparam logic [7:0] LINE_RST   = 8'h0E;
    localparam logic [7:0] LINE_WMASK = 8'h0F;
    localparam logic [7:0] OPEN_BYTE  = 8'hFF;

    localparam logic [2:0] OFS_CMD = 3'd0;
    localparam logic [2:0] OFS_STS = 3'd2;

    function automatic logic [31:0] wide_fill(input logic [1:0] sz);
        return (sz == SZ_HALF) ? 32'h0000FFFF : 32'hFFFFFFFF;
    endfunction
endpackage

// File: rtl/dmareg_chan.sv
module dmareg_chan
    import dmareg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] sub,
    input  logic [7:0] wdata,
    input  logic       drv_irq,
    input  logic       act_set,
    input  logic       act_clr,
    input  logic       err_set,
    output logic [7:0] rd_byte,
    output logic       irq_flag
);
    typedef struct packed {
        logic [7:0]  cmd;
        logic [7:0]  sts;
        logic [31:0] prd;
        logic [7:0]  flag;
    } chan_t;

    chan_t s_d, s_q;
    logic  irq_rise;

    always_comb begin
        s_d      = s_q;
        irq_rise = drv_irq & ~s_q.flag[7];
        if (wr_en) begin
            if (sub == OFS_CMD) begin
                s_d.cmd = wdata & CMD_KEEP;
            end else if (sub == OFS_STS) begin
                s_d.sts = (wdata & STS_LOAD) | (s_q.sts & ~wdata & STS_W1C)
                        | {7'b0, s_q.sts[0]};
            end else if (sub[2]) begin
                s_d.prd[{sub[1:0], 3'b000} +: 8] = wdata;
            end
        end
        s_d.prd[1:0] = 2'b00;
        if (act_set)      s_d.sts[0] = 1'b1;
        else if (act_clr) s_d.sts[0] = 1'b0;
        if (err_set)      s_d.sts[1] = 1'b1;
        if (irq_rise)     s_d.sts[2] = 1'b1;
        s_d.flag = {drv_irq, 7'b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        if (sub == OFS_CMD)      rd_byte = s_q.cmd;
        else if (sub == OFS_STS) rd_byte = s_q.sts;
        else if (sub[2])         rd_byte = s_q.prd[{sub[1:0], 3'b000} +: 8];
        else                     rd_byte = OPEN_BYTE;
    end

    assign irq_flag = s_q.flag[7];

    // R4: only start and direction survive a command write
    p_cmd_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sub == OFS_CMD) |=> (s_q.cmd == ($past(wdata) & CMD_KEEP)));
    // R5: status bit 0 is not writable
    p_sts_keep0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sub == OFS_STS && !act_set && !act_clr) |=> (s_q.sts[0] == $past(s_q.sts[0])));
    // R5: writing one clears the error bit
    p_sts_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sub == OFS_STS && wdata[1] && !err_set) |=> !s_q.sts[1]);
    // R6: hardware error set always lands
    p_err_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> s_q.sts[1]);
    // R7: flag follows the drive line one clock later
    p_flag_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drv_irq |=> irq_flag);
    p_flag_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_irq |=> !irq_flag);
endmodule

// File: rtl/dmareg_irq.sv
module dmareg_irq
    import dmareg_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_we,
    input  logic [7:0]        line_wdata,
    input  logic [NUM_CH-1:0] flags,
    output logic [7:0]        line_q,
    output logic              irq_o
);
    typedef struct packed {
        logic [7:0] line;
    } irq_t;

    irq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (line_we) s_d.line = (s_q.line & ~LINE_WMASK) | (line_wdata & LINE_WMASK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.line <= LINE_RST;
        else        s_q      <= s_d;
    end

    assign line_q = s_q.line;
    assign irq_o  = (|flags) && (s_q.line != 8'h00);

    // R9: only the low nibble takes the written value
    p_line_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        line_we |=> (line_q == {4'h0, $past(line_wdata[3:0])}));
    // R8: a zero line register sampled with a write of zero keeps the output low
    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_we && line_wdata[3:0] == 4'h0) |=> !irq_o);
endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
    import dmareg_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_we,
    input  logic [1:0]                  bus_size,
    input  logic [$clog2(NUM_CH)+2:0]   bus_addr,
    input  logic [7:0]                  bus_wdata,
    output logic [31:0]                 rd_data,
    output logic                        rd_valid,
    input  logic [NUM_CH-1:0]           drv_irq,
    input  logic [NUM_CH-1:0]           dma_act_set,
    input  logic [NUM_CH-1:0]           dma_act_clr,
    input  logic [NUM_CH-1:0]           dma_err_set,
    input  logic                        line_we,
    input  logic [7:0]                  line_wdata,
    output logic [7:0]                  line_q,
    output logic [NUM_CH-1:0]           irq_flag,
    output logic                        irq_out
);
    localparam int AW = $clog2(NUM_CH) + 3;

    typedef struct packed {
        logic [31:0] rdata;
        logic        rvalid;
    } rd_t;

    rd_t        s_d, s_q;
    logic [7:0] chan_rd [NUM_CH];
    logic       byte_acc;

    assign byte_acc = (bus_size == SZ_BYTE);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic hit;
        assign hit = bus_sel && bus_we && byte_acc && (bus_addr[AW-1:3] == g);
        dmareg_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (hit),
            .sub      (bus_addr[2:0]),
            .wdata    (bus_wdata),
            .drv_irq  (drv_irq[g]),
            .act_set  (dma_act_set[g]),
            .act_clr  (dma_act_clr[g]),
            .err_set  (dma_err_set[g]),
            .rd_byte  (chan_rd[g]),
            .irq_flag (irq_flag[g])
        );
    end

    dmareg_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_we    (line_we),
        .line_wdata (line_wdata),
        .flags      (irq_flag),
        .line_q     (line_q),
        .irq_o      (irq_out)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = bus_sel && !bus_we;
        if (bus_sel && !bus_we) begin
            s_d.rdata = byte_acc ? {24'h0, chan_rd[bus_addr[AW-1:3]]} : wide_fill(bus_size);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data  = s_q.rdata;
    assign rd_valid = s_q.rvalid;

    // R12: every read strobe yields a valid pulse next cycle
    p_rd_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we) |=> rd_valid);
    p_no_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |=> !rd_valid);
    // R1: a word read returns all ones
    p_wide_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_size[1]) |=> (rd_data == 32'hFFFFFFFF));
    // R3: open offsets read as 0xFF
    p_open_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && byte_acc && bus_addr[0] && !bus_addr[2]) |=> (rd_data == 32'h000000FF));
endmodule

// File: tb/tb_dmareg_top.sv
module tb_dmareg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [3:0]  bus_addr = 4'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [1:0]  drv_irq = 2'b00;
    logic [1:0]  dma_act_set = 2'b00;
    logic [1:0]  dma_act_clr = 2'b00;
    logic [1:0]  dma_err_set = 2'b00;
    logic        line_we = 1'b0;
    logic [7:0]  line_wdata = 8'd0;
    logic [7:0]  line_q;
    logic [1:0]  irq_flag;
    logic        irq_out;

    int          checks = 0;
    int          fails = 0;
    bit          done = 0;
    logic [31:0] exp_data_q[$];
    string       exp_tag_q[$];

    always #5 clk = ~clk;

    dmareg_top dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .drv_irq(drv_irq),
        .dma_act_set(dma_act_set), .dma_act_clr(dma_act_clr),
        .dma_err_set(dma_err_set), .line_we(line_we), .line_wdata(line_wdata),
        .line_q(line_q), .irq_flag(irq_flag), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // driver: read pushes the expected item for the monitor
    task automatic rd(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a; bus_size = sz;
        exp_data_q.push_back(exp);
        exp_tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
        check("R12 write gives no valid", {31'b0, rd_valid}, 32'd0);
    endtask

    task automatic line_wr(input logic [7:0] d);
        @(negedge clk);
        line_we = 1; line_wdata = d;
        @(negedge clk);
        line_we = 0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_data_q.size() == 0) begin
                check("R12 unexpected valid", 32'd1, 32'd0);
            end else begin
                check(exp_tag_q.pop_front(), rd_data, exp_data_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check("watchdog expired", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        check("R11 line reset", {24'h0, line_q}, 32'h0E);
        check("R11 irq low", {31'h0, irq_out}, 32'd0);
        check("R11 flags clear", {30'h0, irq_flag}, 32'd0);
        rd(4'd0, 2'd0, 32'h00, "R11 ch0 cmd");
        rd(4'd2, 2'd0, 32'h00, "R11 ch0 status");
        rd(4'd14, 2'd0, 32'h00, "R11 ch1 addr byte");
        // R3 open offsets
        rd(4'd1, 2'd0, 32'hFF, "R3 offset1");
        rd(4'd11, 2'd0, 32'hFF, "R3 offset3 ch1");
        wr(4'd1, 2'd0, 8'h12);
        rd(4'd0, 2'd0, 32'h00, "R3 open write leaves cmd");
        rd(4'd1, 2'd0, 32'hFF, "R3 offset1 after write");
        // R4 command mask, R2 channel separation
        wr(4'd0, 2'd0, 8'hFF);
        rd(4'd0, 2'd0, 32'h09, "R4 cmd ch0");
        rd(4'd8, 2'd0, 32'h00, "R2 ch1 cmd untouched");
        wr(4'd8, 2'd0, 8'h08);
        rd(4'd8, 2'd0, 32'h08, "R4 cmd ch1");
        rd(4'd0, 2'd0, 32'h09, "R2 ch0 cmd kept");
        // R10 address lanes
        wr(4'd12, 2'd0, 8'h37);
        wr(4'd13, 2'd0, 8'h22);
        wr(4'd14, 2'd0, 8'h11);
        wr(4'd15, 2'd0, 8'hAB);
        rd(4'd12, 2'd0, 32'h34, "R10 addr byte0 low bits zero");
        rd(4'd13, 2'd0, 32'h22, "R10 addr byte1");
        rd(4'd14, 2'd0, 32'h11, "R10 addr byte2");
        rd(4'd15, 2'd0, 32'hAB, "R10 addr byte3");
        rd(4'd4, 2'd0, 32'h00, "R2 ch0 addr untouched");
        // R1 wide accesses
        rd(4'd0, 2'd2, 32'hFFFFFFFF, "R1 word read");
        rd(4'd2, 2'd1, 32'h0000FFFF, "R1 half read");
        wr(4'd0, 2'd2, 8'h00);
        wr(4'd8, 2'd1, 8'h00);
        rd(4'd0, 2'd0, 32'h09, "R1 wide write ch0 dropped");
        rd(4'd8, 2'd0, 32'h08, "R1 half write ch1 dropped");
        // R6 hardware sets
        @(negedge clk);
        dma_act_set = 2'b01; dma_err_set = 2'b01; drv_irq = 2'b01;
        @(negedge clk);
        dma_act_set = 2'b00; dma_err_set = 2'b00;
        check("R7 flag ch0 set", {30'h0, irq_flag}, 32'h1);
        check("R8 irq out with line 0x0E", {31'h0, irq_out}, 32'd1);
        rd(4'd2, 2'd0, 32'h07, "R6 status after pulses");
        // R5 status write classes
        wr(4'd2, 2'd0, 8'h62);
        rd(4'd2, 2'd0, 32'h65, "R5 load 6:5 clear 1");
        wr(4'd2, 2'd0, 8'h04);
        rd(4'd2, 2'd0, 32'h01, "R5 clear 2 unload 6:5");
        wr(4'd2, 2'd0, 8'hFF);
        rd(4'd2, 2'd0, 32'h61, "R5 reserved zero bit0 kept");
        // R6 hardware set beats write clear
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = 4'd2; bus_size = 2'd0; bus_wdata = 8'h02;
        dma_err_set = 2'b01;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; dma_err_set = 2'b00;
        rd(4'd2, 2'd0, 32'h03, "R6 set wins over clear");
        @(negedge clk);
        dma_act_clr = 2'b01;
        @(negedge clk);
        dma_act_clr = 2'b00;
        rd(4'd2, 2'd0, 32'h02, "R6 active cleared");
        // R8 gating, R9 mask
        line_wr(8'h00);
        check("R9 line zero", {24'h0, line_q}, 32'h00);
        check("R8 gated off", {31'h0, irq_out}, 32'd0);
        line_wr(8'hF5);
        check("R9 upper bits not writable", {24'h0, line_q}, 32'h05);
        check("R8 gated on", {31'h0, irq_out}, 32'd1);
        @(negedge clk);
        drv_irq = 2'b10;
        @(negedge clk);
        check("R7 flags move to ch1", {30'h0, irq_flag}, 32'h2);
        check("R8 OR from ch1", {31'h0, irq_out}, 32'd1);
        rd(4'd10, 2'd0, 32'h04, "R6 ch1 rising edge sets bit2");
        @(negedge clk);
        drv_irq = 2'b00;
        @(negedge clk);
        check("R7 flags clear", {30'h0, irq_flag}, 32'h0);
        check("R8 no source low", {31'h0, irq_out}, 32'd0);
        // R11 reset mid-run
        repeat (2) @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R11 line back to reset", {24'h0, line_q}, 32'h0E);
        rd(4'd0, 2'd0, 32'h00, "R11 cmd cleared");
        rd(4'd10, 2'd0, 32'h00, "R11 ch1 status cleared");
        rd(4'd13, 2'd0, 32'h00, "R11 addr cleared");
        repeat (3) @(negedge clk);
        check("R12 all reads answered", exp_data_q.size(), 32'd0);
        finish_run();
    end
endmodule